// File: doc/BRIEF.md
# Serial Controller Status and Mode Register

This block keeps the run/config state, the master-select state and six sticky error flags of a serial controller. Software never writes the status word directly. It writes a 16-bit command word in which every flag owns one bit that sets it and a separate bit that clears it. Each flag therefore changes only where the command asks, and the other flags keep their values without a read-modify-write.

Five hardware error events can also set flags: transmit overflow, receive overflow, abort, transmit underflow and receive underflow. Each event is gated by its own check-enable input. The mode error flag is changed by software only. An error interrupt stays high while any error flag is set. The busy input from the serial datapath appears in the status word. A request to leave run mode that arrives while busy is high is held back until the datapath goes idle.

Top module: `sstat_cmd_reg`

## Requirements
- R1: After reset, status_o reads zero except for the busy mirror, so the module is in config mode and not master, and err_irq_o is low.
- R2: Command bit 1 sets run enable (status bit 0) and bit 0 clears it. Command bit 3 sets master select (status bit 1) and bit 2 clears it. The change is visible one clock after the write.
- R3: Error flags use these (set bit, clear bit, status bit) triples: TX error (12, 8, 8), RX error (13, 9, 9), abort (14, 10, 10), TX underflow (15, 11, 11), RX underflow (5, 4, 12), mode error (7, 6, 14).
- R4: A command that carries both the set bit and the clear bit of a flag leaves that flag at its previous value.
- R5: hw_err_i[k] sets its flag on the next clock only while err_chk_en_i[k] is high. The index order is TX overflow→status 8, RX overflow→9, abort→10, TX underflow→11, RX underflow→12. With the enable low, the event has no effect.
- R6: A hardware error event in the same cycle as a software clear of its flag leaves the flag set.
- R7: The command 0x0F50 clears all six error flags and leaves run enable and master select unchanged.
- R8: err_irq_o is high exactly when at least one error flag (status bits 8–12, 14) is set. It stays high over idle cycles until the flags are cleared.
- R9: status_o bit 13 follows busy_i in the same cycle, without a register.
- R10: A clear of run enable while busy_i is high keeps enable at 1 until the first clock edge at which busy_i is low. A set-enable command given before that edge cancels the deferred clear.
- R11: While cmd_we_i is low, cmd_i has no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_we_i | input | 1 | Command word write strobe |
| cmd_i | input | 16 | Set/clear command word |
| busy_i | input | 1 | Datapath transfer in progress |
| hw_err_i | input | 5 | Hardware error event pulses |
| err_chk_en_i | input | 5 | Per-event check enables |
| status_o | output | 16 | Status word |
| err_irq_o | output | 1 | Error interrupt, OR of error flags |

## Verification
Every one of the eight flags is driven through all three command shapes: set only, clear only, and both together. Each shape is applied from both starting values, so a swapped bit position, a reversed set/clear priority or a both-bits case that toggles shows up as a wrong bit. All 32 check-enable patterns are applied with every hardware event firing, which separates a missing gate or a crossed index from correct gating. Separate sequences cover an event that collides with a clear-all, a clear of enable while busy (held, then released), a cancelled deferred clear, and writes with the strobe low.

// File: rtl/sstat_pkg.sv
package sstat_pkg;
  localparam int CMD_W      = 16;
  localparam int STAT_W     = 16;
  localparam int NUM_ERR    = 6;
  localparam int NUM_HW_ERR = 5;

  localparam int CMD_EN_CLR = 0;
  localparam int CMD_EN_SET = 1;
  localparam int CMD_MS_CLR = 2;
  localparam int CMD_MS_SET = 3;

  localparam int ST_EN   = 0;
  localparam int ST_MS   = 1;
  localparam int ST_BUSY = 13;

  // error flag order: tx err, rx err, abort, tx udf, rx udf, mode err
  localparam int ERR_SET_POS [NUM_ERR] = '{12, 13, 14, 15, 5, 7};
  localparam int ERR_CLR_POS [NUM_ERR] = '{8, 9, 10, 11, 4, 6};
  localparam int ERR_ST_POS  [NUM_ERR] = '{8, 9, 10, 11, 12, 14};
endpackage

// File: rtl/sstat_flag_cell.sv
module sstat_flag_cell #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic hw_set_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               q_o <= RST_VAL;
    else if (hw_set_i)         q_o <= 1'b1;  // hardware wins over software clear
    else if (set_i && !clr_i)  q_o <= 1'b1;
    else if (clr_i && !set_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/sstat_run_ctrl.sv
module sstat_run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic busy_i,
  output logic en_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      pend_q <= 1'b0;
    end else if (set_i && !clr_i) begin
      en_o   <= 1'b1;
      pend_q <= 1'b0;
    end else if (clr_i && !set_i) begin
      if (busy_i) pend_q <= 1'b1;   // defer config mode until idle
      else begin
        en_o   <= 1'b0;
        pend_q <= 1'b0;
      end
    end else if (pend_q && !busy_i) begin
      en_o   <= 1'b0;
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sstat_err_bank.sv
module sstat_err_bank
  import sstat_pkg::*;
#(
  parameter int N_ERR = NUM_ERR,
  parameter int N_HW  = NUM_HW_ERR
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic [N_HW-1:0]  hw_err_i,
  input  logic [N_HW-1:0]  chk_en_i,
  output logic [N_ERR-1:0] err_o
);
  for (genvar k = 0; k < N_ERR; k++) begin : g_err
    logic hw_set;
    if (k < N_HW) begin : g_hw
      assign hw_set = hw_err_i[k] & chk_en_i[k];
    end else begin : g_sw
      assign hw_set = 1'b0;
    end
    sstat_flag_cell #(.RST_VAL(1'b0)) u_cell (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (cmd_i[ERR_SET_POS[k]]),
      .clr_i    (cmd_i[ERR_CLR_POS[k]]),
      .hw_set_i (hw_set),
      .q_o      (err_o[k])
    );
  end
endmodule

// File: rtl/sstat_cmd_reg.sv
module sstat_cmd_reg
  import sstat_pkg::*;
#(
  parameter int N_HW = NUM_HW_ERR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              busy_i,
  input  logic [N_HW-1:0]   hw_err_i,
  input  logic [N_HW-1:0]   err_chk_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              err_irq_o
);
  logic [CMD_W-1:0]   cmd_eff;
  logic               en_q, ms_q;
  logic [NUM_ERR-1:0] err_q;

  assign cmd_eff = cmd_we_i ? cmd_i : '0;

  sstat_run_ctrl u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cmd_eff[CMD_EN_SET]),
    .clr_i  (cmd_eff[CMD_EN_CLR]),
    .busy_i (busy_i),
    .en_o   (en_q)
  );

  sstat_flag_cell #(.RST_VAL(1'b0)) u_ms (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (cmd_eff[CMD_MS_SET]),
    .clr_i    (cmd_eff[CMD_MS_CLR]),
    .hw_set_i (1'b0),
    .q_o      (ms_q)
  );

  sstat_err_bank #(.N_ERR(NUM_ERR), .N_HW(N_HW)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cmd_i    (cmd_eff),
    .hw_err_i (hw_err_i),
    .chk_en_i (err_chk_en_i),
    .err_o    (err_q)
  );

  always_comb begin
    status_o = '0;
    status_o[ST_EN]   = en_q;
    status_o[ST_MS]   = ms_q;
    for (int k = 0; k < NUM_ERR; k++) status_o[ERR_ST_POS[k]] = err_q[k];
    status_o[ST_BUSY] = busy_i;
  end

  assign err_irq_o = |err_q;
endmodule

// File: rtl/sstat_cmd_reg_chk.sv
module sstat_cmd_reg_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cmd_we_i,
  input logic [15:0] cmd_i,
  input logic        busy_i,
  input logic [4:0]  hw_err_i,
  input logic [4:0]  err_chk_en_i,
  input logic [15:0] status_o,
  input logic        err_irq_o
);
  logic [5:0] err_bits;
  assign err_bits = {status_o[14], status_o[12:8]};

  p_irq_or_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_irq_o == (|err_bits));

  p_busy_mirror_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[13] == busy_i);

  p_ms_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[3] && !cmd_i[2] |=> status_o[1]);

  p_ms_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[2] && !cmd_i[3] |=> !status_o[1]);

  p_ms_both_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i[2] && cmd_i[3] |=> $stable(status_o[1]));

  p_hw_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_err_i[0] && err_chk_en_i[0] |=> status_o[8]);

  p_hw_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hw_err_i[0] && err_chk_en_i[0]) && !(cmd_we_i && cmd_i[12]) |=> !$rose(status_o[8]));

  p_hw_vs_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_err_i[4] && err_chk_en_i[4] && cmd_we_i && cmd_i[4] |=> status_o[12]);

  p_wipe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i == 16'h0F50 && hw_err_i == 5'd0
    |=> (err_bits == 6'd0) && $stable(status_o[1]));

  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && status_o[0] |=> status_o[0]);

  p_no_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_we_i |=> $stable(status_o[1]));
endmodule

bind sstat_cmd_reg sstat_cmd_reg_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_we_i     (cmd_we_i),
  .cmd_i        (cmd_i),
  .busy_i       (busy_i),
  .hw_err_i     (hw_err_i),
  .err_chk_en_i (err_chk_en_i),
  .status_o     (status_o),
  .err_irq_o    (err_irq_o)
);

// File: tb/sstat_cmd_reg_test.sv
module sstat_cmd_reg_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_we;
  logic [15:0] cmd;
  logic        busy;
  logic [4:0]  hw;
  logic [4:0]  chk_en;
  logic [15:0] status;
  logic        irq;

  int errs = 0;
  int checks = 0;
  logic [15:0] m;  // expected flags, busy excluded

  localparam logic [15:0] ERR_MASK = 16'h5F00;
  // flag order: enable, master, tx err, rx err, abort, tx udf, rx udf, mode err
  int set_b [8] = '{1, 3, 12, 13, 14, 15, 5, 7};
  int clr_b [8] = '{0, 2, 8, 9, 10, 11, 4, 6};
  int st_b  [8] = '{0, 1, 8, 9, 10, 11, 12, 14};

  always #10 clk = ~clk;

  sstat_cmd_reg uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .cmd_we_i     (cmd_we),
    .cmd_i        (cmd),
    .busy_i       (busy),
    .hw_err_i     (hw),
    .err_chk_en_i (chk_en),
    .status_o     (status),
    .err_irq_o    (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [15:0] c, input logic [4:0] h, input logic [4:0] e);
    @(negedge clk);
    cmd_we = we; cmd = c; hw = h; chk_en = e;
    @(posedge clk);
    #1;
    cmd_we = 1'b0; cmd = '0; hw = '0; chk_en = '0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #4_000_000;
    errs++; checks++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_we = 0; cmd = '0; busy = 0; hw = '0; chk_en = '0; m = '0;
    #5;
    chk("R1 status after reset", status, 16'h0000);
    chk("R1 irq after reset", irq, 0);
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R2 R3 R4: each flag, each start value, each command shape
    for (int f = 0; f < 8; f++) begin
      for (int init = 0; init < 2; init++) begin
        for (int sc = 1; sc < 4; sc++) begin
          cyc(1, init ? (16'h1 << set_b[f]) : (16'h1 << clr_b[f]), 0, 0);
          m[st_b[f]] = init[0];
          cyc(1, ((sc & 1) ? (16'h1 << set_b[f]) : 16'h0) | ((sc & 2) ? (16'h1 << clr_b[f]) : 16'h0), 0, 0);
          if (sc == 1) m[st_b[f]] = 1'b1;
          else if (sc == 2) m[st_b[f]] = 1'b0;
          if (sc == 3) chk("R4 set+clear keeps flag", status, m);
          else if (f < 2) chk("R2 enable/master command", status, m);
          else chk("R3 error flag command", status, m);
          chk("R8 irq follows flags", irq, |(m & ERR_MASK));
        end
      end
    end

    // R11: strobe low
    cyc(1, 16'h0F55, 0, 0); m = '0;
    cyc(0, 16'hF0AA, 0, 0);
    chk("R11 command ignored without strobe", status, m);

    // R7: set everything, then wipe errors
    cyc(1, 16'hF0AA, 0, 0); m = 16'h5F03;
    chk("R3 set all flags", status, m);
    cyc(1, 16'h0F50, 0, 0); m = 16'h0003;
    chk("R7 wipe keeps enable and master", status, m);
    chk("R8 irq low after wipe", irq, 0);

    // R5: every enable pattern with all events firing
    for (int p = 0; p < 32; p++) begin
      cyc(1, 16'h0F50, 0, 0); m &= ~ERR_MASK;
      cyc(0, 16'h0000, 5'h1F, p[4:0]);
      m |= {3'b000, p[4:0], 8'h00};
      chk("R5 gated hardware events", status, m);
      chk("R8 irq from hardware flags", irq, p != 0);
    end

    // R6: event collides with clear-all
    cyc(1, 16'h00C0 | 16'h0080, 0, 0); m[14] = 1'b1;  // set mode error (both bits -> hold, so use set only below)
    cyc(1, 16'h0080, 0, 0); m[14] = 1'b1;
    cyc(1, 16'h0F50, 5'h1F, 5'h1F); m = (m & ~ERR_MASK) | 16'h1F00;
    chk("R6 hardware event beats clear", status, m);
    repeat (3) cyc(0, 0, 0, 0);
    chk("R8 irq stays while flags set", irq, 1);
    cyc(1, 16'h0F50, 0, 0); m &= ~ERR_MASK;
    chk("R8 irq drops after clear", irq, 0);

    // R9 and R10: deferred leave of run mode
    cyc(1, 16'h0002, 0, 0); m[0] = 1'b1;
    @(negedge clk) busy = 1'b1;
    #1 chk("R9 busy visible same cycle", status[13], 1);
    cyc(1, 16'h0001, 0, 0);
    chk("R10 enable held while busy", status[0], 1);
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("R10 enable still held", status[0], 1);
    @(negedge clk) busy = 1'b0;
    #1 chk("R9 busy cleared same cycle", status[13], 0);
    chk("R10 enable before idle edge", status[0], 1);
    @(posedge clk); #1;
    chk("R10 enable drops at idle edge", status[0], 0);

    cyc(1, 16'h0002, 0, 0);
    @(negedge clk) busy = 1'b1;
    cyc(1, 16'h0001, 0, 0);
    cyc(1, 16'h0002, 0, 0);
    @(negedge clk) busy = 1'b0;
    cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    chk("R10 set cancels deferred clear", status[0], 1);
    cyc(1, 16'h0001, 0, 0);
    chk("R10 clear while idle is immediate", status[0], 0);

    summary();
    $finish;
  end
endmodule